// File: doc/BRIEF.md
# Two-Unit Instruction Fetch and Decode Front End

This block reads one instruction from a memory port that delivers 16-bit halfwords. It then turns the instruction into an operation identifier and the register fields that execution needs. When it sees a start pulse, it copies the next program counter into its own PC and requests the first halfword at that address. The top six bits of that halfword, the major opcode, tell the block whether the instruction continues. If it does, a second request goes out at PC+2, and only after the first halfword has come back.

Most major opcodes map straight to one operation. Two opcodes are groups that need a second decode step. One group takes its sub-operation from the five low bits of the first halfword. The other takes it from the six top bits of the second halfword. Any code that has no meaning gives a dedicated illegal operation rather than a random value.

When decoding finishes, a single-cycle done strobe goes out. The operation, the two register fields and the immediate halfword stay fixed until the next instruction completes.

Top module: `insn_fetch_decoder`

## Requirements
- R1: While reset is high and on the first cycle after it, `done` and `fetch_req` are 0. `op_id` is OP_ILLEGAL (value 0), and `reg1`, `reg2` and `imm_unit` are 0.
- R2: A start pulse in idle captures `next_pc`. The first halfword is requested at that address, and a second one, when needed, at that address plus 2.
- R3: A major opcode (first halfword bits [15:10]) in the range 0..39, or equal to 50 or 54, fetches exactly one halfword. Every other opcode fetches exactly two.
- R4: No request is raised while an accepted request still waits for its data.
- R5: A request not yet accepted (`fetch_ready` low) stays raised with an unchanged address on the next cycle.
- R6: `reg1` is first-halfword bits [4:0] and `reg2` is bits [9:5`]. `imm_unit` is the second halfword for two-halfword instructions and 0 otherwise.
- R7: The major opcodes map to the package enum `ifd_pkg::op_e` as follows:
  - 0 and 16 give OP_MOV; 1 and 17 give OP_ADD.
  - 32..39 all give OP_BRANCH; 27, 50 and 54 give OP_ILLEGAL.
  - 40 gives OP_MOVEA; 47 gives OP_MOVHI; 63 gives OP_OUT_W.
  - The remaining codes follow the package table.
- R8: Opcode 31 is decoded again from first-halfword bits [4:0]:
  - 0 and 2 give OP_BSTR_UP;
  - 1 and 3 give OP_BSTR_DOWN;
  - 8..15 give OP_BSTR_LOGIC;
  - all other values give OP_ILLEGAL.
- R9: Opcode 62 is decoded again from second-halfword bits [15:10]:
  - 0 gives OP_FCMP, 2 gives OP_I2F, 3 gives OP_F2I and 4..7 give OP_FADD/OP_FSUB/OP_FMUL/OP_FDIV;
  - 8..12 give OP_SWAP_B, OP_SWAP_H, OP_BITREV, OP_F2I_TRUNC and OP_MULHW;
  - 1 and 13..63 give OP_ILLEGAL.
- R10: `done` is high for exactly one cycle per instruction. The decoded outputs change only in a cycle where `done` is high.
- R11: A start pulse while an instruction is in flight is ignored: no extra done, and no request from the new `next_pc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin fetching one instruction |
| next_pc | input | AW | Address of the instruction to fetch |
| fetch_req | output | 1 | Halfword read request |
| fetch_addr | output | AW | Halfword read address |
| fetch_ready | input | 1 | Memory accepts the request this cycle |
| fetch_rvalid | input | 1 | Read data valid |
| fetch_rdata | input | 16 | Read halfword |
| done | output | 1 | One-cycle strobe: decode complete |
| op_id | output | 7 | Decoded operation identifier |
| reg1 | output | 5 | First register field |
| reg2 | output | 5 | Second register field |
| imm_unit | output | 16 | Second halfword, or 0 |

## Verification
On every cycle, the assertions check the port protocol:
- one outstanding request at most;
- requests held, with a fixed address, while they are stalled;
- a done strobe one cycle wide;
- decoded outputs that stay unchanged between strobes;
- a halfword count that matches the opcode of the returned first unit.

The mapping from codes to operations is a different matter. Only the bench scenarios can show it: both group decodes, the illegal codes, the immediate value, the addresses used, and a start pulse that arrives mid-fetch being ignored.

// File: rtl/ifd_pkg.sv
package ifd_pkg;

    localparam int UNIT_W = 16;
    localparam int OPC_W  = 6;
    localparam int REG_W  = 5;
    localparam int OP_W   = 7;

    localparam logic [OPC_W-1:0] OPC_BSTR_GROUP = 6'd31;
    localparam logic [OPC_W-1:0] OPC_EXT_GROUP  = 6'd62;

    typedef enum logic [OP_W-1:0] {
        OP_ILLEGAL = 7'd0,
        OP_MOV, OP_ADD, OP_SUB, OP_CMP, OP_SHL, OP_SHR, OP_JMP, OP_SAR,
        OP_MUL, OP_DIV, OP_MULU, OP_DIVU, OP_OR, OP_AND, OP_XOR, OP_NOT,
        OP_SETF, OP_INT_OFF, OP_TRAP, OP_RETI, OP_HALT, OP_SYSREG_WR,
        OP_SYSREG_RD, OP_INT_ON, OP_BRANCH, OP_MOVEA, OP_ADDI, OP_JR, OP_JAL,
        OP_ORI, OP_ANDI, OP_XORI, OP_MOVHI, OP_LD_B, OP_LD_H, OP_LD_W,
        OP_ST_B, OP_ST_H, OP_ST_W, OP_IN_B, OP_IN_H, OP_IN_W, OP_CMPXCHG,
        OP_OUT_B, OP_OUT_H, OP_OUT_W, OP_BSTR_UP, OP_BSTR_DOWN, OP_BSTR_LOGIC,
        OP_FCMP, OP_I2F, OP_F2I, OP_FADD, OP_FSUB, OP_FMUL, OP_FDIV,
        OP_SWAP_B, OP_SWAP_H, OP_BITREV, OP_F2I_TRUNC, OP_MULHW
    } op_e;

    typedef enum logic [2:0] {
        SEQ_IDLE, SEQ_REQ_A, SEQ_WAIT_A, SEQ_REQ_B, SEQ_WAIT_B
    } seq_e;

    // True when the major opcode carries a second halfword.
    function automatic logic needs_second(input logic [OPC_W-1:0] opc);
        return (opc >= 6'd40) && (opc != 6'd50) && (opc != 6'd54);
    endfunction

    function automatic op_e major_op(input logic [OPC_W-1:0] opc);
        if (opc >= 6'd32 && opc <= 6'd39) return OP_BRANCH;
        case (opc)
            6'd0, 6'd16:  return OP_MOV;
            6'd1, 6'd17:  return OP_ADD;
            6'd2:         return OP_SUB;
            6'd3, 6'd19:  return OP_CMP;
            6'd4, 6'd20:  return OP_SHL;
            6'd5, 6'd21:  return OP_SHR;
            6'd6:         return OP_JMP;
            6'd7, 6'd23:  return OP_SAR;
            6'd8:         return OP_MUL;
            6'd9:         return OP_DIV;
            6'd10:        return OP_MULU;
            6'd11:        return OP_DIVU;
            6'd12:        return OP_OR;
            6'd13:        return OP_AND;
            6'd14:        return OP_XOR;
            6'd15:        return OP_NOT;
            6'd18:        return OP_SETF;
            6'd22:        return OP_INT_OFF;
            6'd24:        return OP_TRAP;
            6'd25:        return OP_RETI;
            6'd26:        return OP_HALT;
            6'd28:        return OP_SYSREG_WR;
            6'd29:        return OP_SYSREG_RD;
            6'd30:        return OP_INT_ON;
            6'd40:        return OP_MOVEA;
            6'd41:        return OP_ADDI;
            6'd42:        return OP_JR;
            6'd43:        return OP_JAL;
            6'd44:        return OP_ORI;
            6'd45:        return OP_ANDI;
            6'd46:        return OP_XORI;
            6'd47:        return OP_MOVHI;
            6'd48:        return OP_LD_B;
            6'd49:        return OP_LD_H;
            6'd51:        return OP_LD_W;
            6'd52:        return OP_ST_B;
            6'd53:        return OP_ST_H;
            6'd55:        return OP_ST_W;
            6'd56:        return OP_IN_B;
            6'd57:        return OP_IN_H;
            6'd58:        return OP_CMPXCHG;
            6'd59:        return OP_IN_W;
            6'd60:        return OP_OUT_B;
            6'd61:        return OP_OUT_H;
            6'd63:        return OP_OUT_W;
            default:      return OP_ILLEGAL;
        endcase
    endfunction

    function automatic op_e bstr_op(input logic [REG_W-1:0] sub);
        if (sub[4:3] == 2'b01) return OP_BSTR_LOGIC;
        case (sub)
            5'd0, 5'd2: return OP_BSTR_UP;
            5'd1, 5'd3: return OP_BSTR_DOWN;
            default:    return OP_ILLEGAL;
        endcase
    endfunction

    function automatic op_e ext_op(input logic [OPC_W-1:0] sub);
        case (sub)
            6'd0:    return OP_FCMP;
            6'd2:    return OP_I2F;
            6'd3:    return OP_F2I;
            6'd4:    return OP_FADD;
            6'd5:    return OP_FSUB;
            6'd6:    return OP_FMUL;
            6'd7:    return OP_FDIV;
            6'd8:    return OP_SWAP_B;
            6'd9:    return OP_SWAP_H;
            6'd10:   return OP_BITREV;
            6'd11:   return OP_F2I_TRUNC;
            6'd12:   return OP_MULHW;
            default: return OP_ILLEGAL;
        endcase
    endfunction

endpackage

// File: rtl/ifd_fetch_seq.sv
module ifd_fetch_seq
    import ifd_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [AW-1:0]     next_pc,
    output logic              fetch_req,
    output logic [AW-1:0]     fetch_addr,
    input  logic              fetch_ready,
    input  logic              fetch_rvalid,
    input  logic [UNIT_W-1:0] fetch_rdata,
    output logic              fin,
    output logic [UNIT_W-1:0] fin_u0,
    output logic [UNIT_W-1:0] fin_u1
);
    localparam logic [AW-1:0] UNIT_BYTES = AW'(UNIT_W / 8);

    seq_e              state_q, state_d;
    logic [AW-1:0]     pc_q;
    logic [UNIT_W-1:0] u0_q;
    logic              more;

    assign more = needs_second(fetch_rdata[UNIT_W-1 -: OPC_W]);

    always_comb begin
        state_d    = state_q;
        fetch_req  = 1'b0;
        fetch_addr = pc_q;
        fin        = 1'b0;
        fin_u0     = fetch_rdata;
        fin_u1     = '0;
        case (state_q)
            SEQ_IDLE:   if (start) state_d = SEQ_REQ_A;
            SEQ_REQ_A: begin
                fetch_req = 1'b1;
                if (fetch_ready) state_d = SEQ_WAIT_A;
            end
            SEQ_WAIT_A: if (fetch_rvalid) begin
                state_d = more ? SEQ_REQ_B : SEQ_IDLE;
                fin     = !more;
            end
            SEQ_REQ_B: begin
                fetch_req  = 1'b1;
                fetch_addr = pc_q + UNIT_BYTES;
                if (fetch_ready) state_d = SEQ_WAIT_B;
            end
            SEQ_WAIT_B: begin
                fin_u0 = u0_q;
                fin_u1 = fetch_rdata;
                if (fetch_rvalid) begin
                    state_d = SEQ_IDLE;
                    fin     = 1'b1;
                end
            end
            default:    state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            pc_q    <= '0;
            u0_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == SEQ_IDLE && start) pc_q <= next_pc;
            if (state_q == SEQ_WAIT_A && fetch_rvalid) u0_q <= fetch_rdata;
        end
    end
endmodule

// File: rtl/ifd_decode.sv
module ifd_decode
    import ifd_pkg::*;
(
    input  logic [UNIT_W-1:0] u0,
    input  logic [UNIT_W-1:0] u1,
    output op_e               op,
    output logic [REG_W-1:0]  r1,
    output logic [REG_W-1:0]  r2
);
    logic [OPC_W-1:0] opc;

    assign opc = u0[UNIT_W-1 -: OPC_W];
    assign r1  = u0[REG_W-1:0];
    assign r2  = u0[2*REG_W-1:REG_W];

    always_comb begin
        if (opc == OPC_BSTR_GROUP)     op = bstr_op(u0[REG_W-1:0]);
        else if (opc == OPC_EXT_GROUP) op = ext_op(u1[UNIT_W-1 -: OPC_W]);
        else                           op = major_op(opc);
    end
endmodule

// File: rtl/insn_fetch_decoder.sv
module insn_fetch_decoder
    import ifd_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [AW-1:0]     next_pc,
    output logic              fetch_req,
    output logic [AW-1:0]     fetch_addr,
    input  logic              fetch_ready,
    input  logic              fetch_rvalid,
    input  logic [15:0]       fetch_rdata,
    output logic              done,
    output logic [6:0]        op_id,
    output logic [4:0]        reg1,
    output logic [4:0]        reg2,
    output logic [15:0]       imm_unit
);
    logic              fin;
    logic [UNIT_W-1:0] fin_u0, fin_u1;
    op_e               dec_op;
    logic [REG_W-1:0]  dec_r1, dec_r2;

    ifd_fetch_seq #(.AW(AW)) seq_i (
        .clk(clk), .rst(rst), .start(start), .next_pc(next_pc),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fetch_ready(fetch_ready), .fetch_rvalid(fetch_rvalid),
        .fetch_rdata(fetch_rdata),
        .fin(fin), .fin_u0(fin_u0), .fin_u1(fin_u1)
    );

    ifd_decode dec_i (
        .u0(fin_u0), .u1(fin_u1), .op(dec_op), .r1(dec_r1), .r2(dec_r2)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done     <= 1'b0;
            op_id    <= OP_ILLEGAL;
            reg1     <= '0;
            reg2     <= '0;
            imm_unit <= '0;
        end else begin
            done <= fin;
            if (fin) begin
                op_id    <= dec_op;
                reg1     <= dec_r1;
                reg2     <= dec_r2;
                imm_unit <= fin_u1;
            end
        end
    end
endmodule

// File: rtl/ifd_checker.sv
module ifd_checker
    import ifd_pkg::*;
#(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          fetch_req,
    input logic [AW-1:0] fetch_addr,
    input logic          fetch_ready,
    input logic          fetch_rvalid,
    input logic [15:0]   fetch_rdata,
    input logic          done,
    input logic [6:0]    op_id,
    input logic [4:0]    reg1,
    input logic [4:0]    reg2,
    input logic [15:0]   imm_unit
);
    logic        pend_q;
    logic [1:0]  units_q;
    logic [5:0]  opc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= 1'b0;
            units_q <= '0;
            opc_q   <= '0;
        end else begin
            if (fetch_req && fetch_ready) pend_q <= 1'b1;
            else if (fetch_rvalid)        pend_q <= 1'b0;
            if (done) units_q <= '0;
            else if (fetch_rvalid) begin
                units_q <= units_q + 2'd1;
                if (units_q == 2'd0) opc_q <= fetch_rdata[15:10];
            end
        end
    end

    assert_unit_count_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> (units_q == (needs_second(opc_q) ? 2'd2 : 2'd1)));

    assert_single_outstanding_R4: assert property (@(posedge clk) disable iff (rst)
        pend_q |-> !fetch_req);

    assert_req_held_R5: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && !fetch_ready) |=> (fetch_req && $stable(fetch_addr)));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_outputs_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(op_id) && $stable(reg1) && $stable(reg2) && $stable(imm_unit)));
endmodule

bind insn_fetch_decoder ifd_checker #(.AW(AW)) chk_i (
    .clk(clk), .rst(rst), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .fetch_ready(fetch_ready), .fetch_rvalid(fetch_rvalid),
    .fetch_rdata(fetch_rdata), .done(done), .op_id(op_id), .reg1(reg1),
    .reg2(reg2), .imm_unit(imm_unit)
);

// File: tb/insn_fetch_decoder_tb_top.sv
module insn_fetch_decoder_tb_top;
    import ifd_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] next_pc = '0;
    logic          fetch_req;
    logic [AW-1:0] fetch_addr;
    logic          fetch_ready = 1'b1;
    logic          fetch_rvalid = 1'b0;
    logic [15:0]   fetch_rdata = '0;
    logic          done;
    logic [6:0]    op_id;
    logic [4:0]    reg1, reg2;
    logic [15:0]   imm_unit;

    int n_checks = 0;
    int n_fail = 0;

    logic [15:0]   mem [0:127];
    int            log_n;
    logic [AW-1:0] log_addr [0:3];
    int            done_seen;

    always #(CLK_PERIOD/2) clk = ~clk;

    insn_fetch_decoder #(.AW(AW)) dut_i (
        .clk(clk), .rst(rst), .start(start), .next_pc(next_pc),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fetch_ready(fetch_ready), .fetch_rvalid(fetch_rvalid),
        .fetch_rdata(fetch_rdata), .done(done), .op_id(op_id),
        .reg1(reg1), .reg2(reg2), .imm_unit(imm_unit)
    );

    // Memory model: data returns the cycle after acceptance.
    always @(posedge clk) begin
        fetch_rvalid <= 1'b0;
        if (fetch_req && fetch_ready) begin
            fetch_rvalid <= 1'b1;
            fetch_rdata  <= mem[fetch_addr[7:1]];
            if (log_n < 4) log_addr[log_n] <= fetch_addr;
            log_n <= log_n + 1;
        end
        if (done) done_seen <= done_seen + 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int units_for(input logic [5:0] opc);
        if (opc < 6'd40) return 1;
        if (opc == 6'd50 || opc == 6'd54) return 1;
        return 2;
    endfunction

    // Runs one instruction; returns after the done cycle has been sampled.
    task automatic exec(input logic [AW-1:0] pc, input logic [15:0] u0,
                        input logic [15:0] u1, output bit ok);
        mem[pc[7:1]]        = u0;
        mem[pc[7:1] + 7'd1] = u1;
        @(negedge clk);
        log_n     = 0;
        done_seen = 0;
        next_pc   = pc;
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        ok = 1'b0;
        for (int i = 0; i < 60; i++) begin
            if (done) begin ok = 1'b1; break; end
            @(negedge clk);
        end
        if (!ok) chk(1'b0, "R10", "done timeout", 0, 1);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(done == 1'b0, "R1", "done after reset", done, 0);
        chk(fetch_req == 1'b0, "R1", "fetch_req after reset", fetch_req, 0);
        chk(op_id == 7'(OP_ILLEGAL), "R1", "op after reset", op_id, OP_ILLEGAL);
        chk(reg1 == 0 && reg2 == 0 && imm_unit == 0, "R1", "fields after reset",
            {reg1, reg2, imm_unit}, 0);
    endtask

    task automatic t_insn(input logic [AW-1:0] pc, input logic [15:0] u0,
                          input logic [15:0] u1, input op_e exp_op, input string req);
        bit ok;
        int units;
        logic [6:0] op_s;
        units = units_for(u0[15:10]);
        exec(pc, u0, u1, ok);
        if (!ok) return;
        chk(op_id == 7'(exp_op), req, "op_id", op_id, exp_op);
        chk(reg1 == u0[4:0], "R6", "reg1", reg1, u0[4:0]);
        chk(reg2 == u0[9:5], "R6", "reg2", reg2, u0[9:5]);
        chk(imm_unit == (units == 2 ? u1 : 16'h0), "R6", "imm_unit", imm_unit,
            units == 2 ? u1 : 16'h0);
        chk(log_n == units, "R3", "halfword fetches", log_n, units);
        chk(log_addr[0] == pc, "R2", "first address", log_addr[0], pc);
        if (units == 2) chk(log_addr[1] == pc + 2, "R2", "second address", log_addr[1], pc + 2);
        op_s = op_id;
        repeat (3) @(negedge clk);
        chk(done == 1'b0 && done_seen == 1, "R10", "done pulse count", done_seen, 1);
        chk(op_id == op_s, "R10", "op_id held", op_id, op_s);
    endtask

    task automatic t_length_sweep;
        bit ok;
        for (int opc = 0; opc < 64; opc++) begin
            exec(32'h40, {6'(opc), 10'h021}, 16'h0800, ok);
            chk(log_n == units_for(6'(opc)), "R3", $sformatf("fetches opc %0d", opc),
                log_n, units_for(6'(opc)));
        end
    endtask

    task automatic t_stall;
        logic [AW-1:0] a0;
        fetch_ready = 1'b0;
        mem[7'h10] = {6'd47, 5'd3, 5'd4};
        mem[7'h11] = 16'hBEEF;
        @(negedge clk);
        log_n = 0; done_seen = 0;
        next_pc = 32'h20; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        a0 = fetch_addr;
        repeat (3) begin
            @(negedge clk);
            chk(fetch_req == 1'b1 && fetch_addr == a0, "R5", "held request",
                fetch_addr, a0);
        end
        fetch_ready = 1'b1;
        for (int i = 0; i < 20 && !done; i++) @(negedge clk);
        chk(op_id == 7'(OP_MOVHI) && imm_unit == 16'hBEEF, "R5", "result after stall",
            imm_unit, 16'hBEEF);
        chk(log_n == 2, "R4", "fetches after stall", log_n, 2);
    endtask

    task automatic t_busy_start;
        mem[7'h18] = {6'd40, 5'd1, 5'd2};
        mem[7'h19] = 16'h1234;
        mem[7'h30] = {6'd0, 5'd9, 5'd9};
        @(negedge clk);
        log_n = 0; done_seen = 0;
        next_pc = 32'h30; start = 1'b1;
        @(negedge clk);
        next_pc = 32'h60;
        @(negedge clk);
        @(negedge clk);
        start = 1'b0;
        repeat (12) @(negedge clk);
        chk(done_seen == 1, "R11", "done count with busy start", done_seen, 1);
        chk(log_n == 2, "R11", "fetch count with busy start", log_n, 2);
        chk(log_addr[1] == 32'h32, "R11", "second address unchanged", log_addr[1], 32'h32);
        chk(op_id == 7'(OP_MOVEA), "R11", "op with busy start", op_id, OP_MOVEA);
    endtask

    initial begin
        for (int i = 0; i < 128; i++) mem[i] = '0;
        log_n = 0; done_seen = 0;
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_reset();
        // R7 major decode
        t_insn(32'h00, {6'd0,  5'd7, 5'd3},  16'h0, OP_MOV, "R7");
        t_insn(32'h04, {6'd17, 5'd1, 5'd31}, 16'h0, OP_ADD, "R7");
        t_insn(32'h08, {6'd37, 5'd2, 5'd5},  16'h0, OP_BRANCH, "R7");
        t_insn(32'h0C, {6'd27, 5'd0, 5'd0},  16'h0, OP_ILLEGAL, "R7");
        t_insn(32'h10, {6'd50, 5'd4, 5'd4},  16'hFFFF, OP_ILLEGAL, "R7");
        t_insn(32'h14, {6'd54, 5'd6, 5'd1},  16'hFFFF, OP_ILLEGAL, "R7");
        t_insn(32'h18, {6'd40, 5'd10, 5'd20}, 16'h8001, OP_MOVEA, "R7");
        t_insn(32'h1C, {6'd63, 5'd31, 5'd0}, 16'h5A5A, OP_OUT_W, "R7");
        // R8 bit-string group
        t_insn(32'h20, {6'd31, 5'd0, 5'd0},  16'h0, OP_BSTR_UP, "R8");
        t_insn(32'h24, {6'd31, 5'd0, 5'd3},  16'h0, OP_BSTR_DOWN, "R8");
        t_insn(32'h28, {6'd31, 5'd0, 5'd9},  16'h0, OP_BSTR_LOGIC, "R8");
        t_insn(32'h2C, {6'd31, 5'd0, 5'd20}, 16'h0, OP_ILLEGAL, "R8");
        // R9 extended group
        t_insn(32'h30, {6'd62, 5'd1, 5'd2},  {6'd0, 10'h3FF}, OP_FCMP, "R9");
        t_insn(32'h34, {6'd62, 5'd1, 5'd2},  {6'd1, 10'h0},   OP_ILLEGAL, "R9");
        t_insn(32'h38, {6'd62, 5'd3, 5'd4},  {6'd12, 10'h1},  OP_MULHW, "R9");
        t_insn(32'h3C, {6'd62, 5'd3, 5'd4},  {6'd13, 10'h0},  OP_ILLEGAL, "R9");
        t_length_sweep();
        t_stall();
        t_busy_start();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL R10 watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule